// File: doc/BRIEF.md
# Register-reply frame transmitter

After each register read, this block sends one Ethernet reply frame over a two-bit transmit interface. The interface has a transmit-enable line and a data pair that carries one dibit per clock. A read strobe latches the 16-bit read value. The frame then goes out in this order:

- a preamble and start delimiter
- a header: the host address as destination, the device address as source, and a configurable EtherType
- a fixed 46-byte payload, with the read value in its first two bytes and zeros after it
- a CRC-32 frame check sequence

Write strobes never produce a reply. A busy output is high from the moment a frame is accepted until its inter-frame gap has elapsed. While busy is high, any strobe is dropped and is not queued.

The block sits behind the register file of a command bridge. The bridge presents the read value, the read/write flag and a valid pulse in the same cycle. The block owns the transmit pins from then on.

Top module: `reg_reply_tx`

## Requirements
- R1: After reset, txen_o is 0, txd_o is 2'b00 and busy_o is 0.
- R2: A cycle with valid_i=1, rw_i=0 and busy_o=0 starts a frame. txen_o is 1 from the next cycle and stays 1 for exactly 288 consecutive cycles, which is 72 bytes.
- R3: The frame opens with seven 0x55 bytes and then one 0xD5 byte. Every byte of the frame goes out least significant dibit first: bits [1:0], then [3:2], [5:4] and [7:6].
- R4: Bytes 8 to 13 are HOST_MAC and bytes 14 to 19 are DEV_MAC, each sent most significant byte first. Bytes 20 and 21 are ETHERTYPE, high byte first, default 0x88B5.
- R5: The payload is bytes 22 to 67. Byte 22 is rdata_i[15:8] and byte 23 is rdata_i[7:0], both as latched when the frame was accepted. Bytes 24 to 67 are zero.
- R6: Bytes 68 to 71 carry the complement of a reflected CRC-32 over bytes 8 to 67, least significant byte first. The CRC uses polynomial 0xEDB88320, starts from all ones and takes bits LSB first.
- R7: After txen_o falls, busy_o stays 1 with txen_o at 0 for exactly GAP_CYC cycles (default 48), then returns to 0.
- R8: A strobe with rw_i=1 starts no frame: txen_o and busy_o stay 0.
- R9: A strobe that arrives while busy_o=1 is dropped. The current frame keeps its latched data, and no extra frame follows.
- R10: txd_o is 2'b00 whenever txen_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rdata_i | input | 16 | Register read value |
| rw_i | input | 1 | 1 = write command, 0 = read command |
| valid_i | input | 1 | Command strobe |
| txen_o | output | 1 | Transmit enable |
| txd_o | output | 2 | Transmit dibit |
| busy_o | output | 1 | Frame or gap in progress |

## Verification
Reads are sent with the values 0x0000, 0xFFFF, 0xA55A and 0x1234:
- 0x0000 and 0xFFFF tell whether payload bits are stuck or inverted.
- 0xA55A and 0x1234 reveal byte swaps and dibit-order errors.
- Because the values differ, the check sequences differ too, which exposes CRC faults that a single pattern would hide.

A write strobe tells whether the read/write flag is decoded at all. A second read pulsed in the middle of a frame, with different data, tells dropping apart from queueing or re-latching. Measuring the low-enable stretch after each frame tells whether the gap is too short or too long.

// File: rtl/reg_reply_tx_pkg.sv
package reg_reply_tx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_GAP} phase_e;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
endpackage

// File: rtl/reply_crc_dibit.sv
module reply_crc_dibit
  import reg_reply_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [1:0]  dibit_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    for (int b = 0; b < 2; b++) begin
      if (crc_d[0] ^ dibit_i[b]) crc_d = (crc_d >> 1) ^ CRC_POLY_REFL;
      else                       crc_d = crc_d >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/reply_byte_sel.sv
module reply_byte_sel
  import reg_reply_tx_pkg::*;
#(
  parameter logic [47:0] HOST_MAC  = 48'h0,
  parameter logic [47:0] DEV_MAC   = 48'h0,
  parameter logic [15:0] ETHERTYPE = 16'h88B5,
  parameter int          PRE_LEN   = 7,
  parameter int          PAD_BYTES = 46,
  parameter int          IDX_W     = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      rdata_i,
  input  logic [31:0]      crc_i,
  output logic [7:0]       byte_o
);
  localparam int DstFirst = PRE_LEN + 1;
  localparam int SrcFirst = DstFirst + 6;
  localparam int TypFirst = SrcFirst + 6;
  localparam int PayFirst = TypFirst + 2;
  localparam int FcsFirst = PayFirst + PAD_BYTES;

  logic [31:0] fcs;
  assign fcs = ~crc_i;

  always_comb begin
    int i;
    i = int'(idx_i);
    byte_o = 8'h00;
    if (i < PRE_LEN)            byte_o = PRE_BYTE;
    else if (i < DstFirst)      byte_o = SFD_BYTE;
    else if (i < SrcFirst)      byte_o = HOST_MAC[8*(5-(i-DstFirst)) +: 8];
    else if (i < TypFirst)      byte_o = DEV_MAC[8*(5-(i-SrcFirst)) +: 8];
    else if (i < PayFirst)      byte_o = ETHERTYPE[8*(1-(i-TypFirst)) +: 8];
    else if (i == PayFirst)     byte_o = rdata_i[15:8];
    else if (i == PayFirst + 1) byte_o = rdata_i[7:0];
    else if (i < FcsFirst)      byte_o = 8'h00;
    else                        byte_o = fcs[8*((i-FcsFirst) & 3) +: 8];
  end
endmodule

// File: rtl/reg_reply_tx.sv
module reg_reply_tx
  import reg_reply_tx_pkg::*;
#(
  parameter logic [47:0] HOST_MAC  = 48'h02_11_22_33_44_55,
  parameter logic [47:0] DEV_MAC   = 48'h12_34_56_78_9A_BC,
  parameter logic [15:0] ETHERTYPE = 16'h88B5,
  parameter int          PRE_LEN   = 7,
  parameter int          PAD_BYTES = 46,
  parameter int          GAP_CYC   = 48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] rdata_i,
  input  logic        rw_i,
  input  logic        valid_i,
  output logic        txen_o,
  output logic [1:0]  txd_o,
  output logic        busy_o
);
  localparam int HdrBytes   = 14;
  localparam int CrcFirst   = PRE_LEN + 1;
  localparam int FcsFirst   = CrcFirst + HdrBytes + PAD_BYTES;
  localparam int FrameBytes = FcsFirst + 4;
  localparam int IdxW       = $clog2(FrameBytes);
  localparam int GapW       = $clog2(GAP_CYC + 1);

  phase_e          phase_q;
  logic [IdxW-1:0] idx_q;
  logic [1:0]      dib_q;
  logic [GapW-1:0] gap_q;
  logic [15:0]     data_q;
  logic [7:0]      cur_byte;
  logic [31:0]     crc;
  logic [1:0]      dibit;
  logic            accept, crc_en;

  assign accept = valid_i && !rw_i && (phase_q == PH_IDLE);
  assign dibit  = cur_byte[2*dib_q +: 2];
  assign crc_en = (phase_q == PH_SEND) && (int'(idx_q) >= CrcFirst) && (int'(idx_q) < FcsFirst);

  reply_byte_sel #(
    .HOST_MAC(HOST_MAC), .DEV_MAC(DEV_MAC), .ETHERTYPE(ETHERTYPE),
    .PRE_LEN(PRE_LEN), .PAD_BYTES(PAD_BYTES), .IDX_W(IdxW)
  ) sel_i (
    .idx_i(idx_q), .rdata_i(data_q), .crc_i(crc), .byte_o(cur_byte)
  );

  reply_crc_dibit crc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(accept), .en_i(crc_en),
    .dibit_i(dibit), .crc_o(crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      dib_q   <= '0;
      gap_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_SEND;
          idx_q   <= '0;
          dib_q   <= '0;
          data_q  <= rdata_i;
        end
        PH_SEND: begin
          dib_q <= dib_q + 2'd1;
          if (dib_q == 2'd3) begin
            if (int'(idx_q) == FrameBytes - 1) begin
              phase_q <= PH_GAP;
              gap_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_GAP: begin
          if (int'(gap_q) == GAP_CYC - 1) phase_q <= PH_IDLE;
          else                            gap_q   <= gap_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign txen_o = (phase_q == PH_SEND);
  assign txd_o  = txen_o ? dibit : 2'b00;
  assign busy_o = (phase_q != PH_IDLE);
endmodule

// File: rtl/reg_reply_tx_chk.sv
module reg_reply_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       rw_i,
  input logic       txen_o,
  input logic [1:0] txd_o,
  input logic       busy_o
);
  AST_READ_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rw_i && !busy_o) |=> txen_o); // R2
  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rw_i && !busy_o) |=> !busy_o); // R8
  AST_GAP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txen_o) |-> busy_o); // R7
  AST_TXEN_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txen_o |-> busy_o); // R9
  AST_IDLE_DIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txen_o |-> (txd_o == 2'b00)); // R10
endmodule

bind reg_reply_tx reg_reply_tx_chk chk_i (.*);

// File: tb/reg_reply_tx_tb_top.sv
module reg_reply_tx_tb_top;
  localparam logic [47:0] HOST = 48'h02_11_22_33_44_55;
  localparam logic [47:0] DEV  = 48'h12_34_56_78_9A_BC;
  localparam logic [15:0] ETYP = 16'h88B5;
  localparam int NBYTES = 72;

  logic clk = 0, rst_n = 0;
  logic [15:0] rdata = 0;
  logic rw = 0, valid = 0;
  logic txen, busy;
  logic [1:0] txd;
  int checks = 0, fails = 0;
  logic [7:0] cap [0:NBYTES-1];
  logic [7:0] exp_b [0:NBYTES-1];
  int ndib, gapn;

  always #10 clk = ~clk;

  reg_reply_tx #(.HOST_MAC(HOST), .DEV_MAC(DEV), .ETHERTYPE(ETYP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rdata_i(rdata), .rw_i(rw), .valid_i(valid),
    .txen_o(txen), .txd_o(txd), .busy_o(busy));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_exp(input logic [15:0] d);
    logic [31:0] c;
    for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
    exp_b[7] = 8'hD5;
    for (int i = 0; i < 6; i++) begin
      exp_b[8+i]  = HOST[8*(5-i) +: 8];
      exp_b[14+i] = DEV[8*(5-i) +: 8];
    end
    exp_b[20] = ETYP[15:8];
    exp_b[21] = ETYP[7:0];
    exp_b[22] = d[15:8];
    exp_b[23] = d[7:0];
    for (int i = 24; i < 68; i++) exp_b[i] = 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 8; i < 68; i++)
      for (int j = 0; j < 8; j++)
        if (c[0] ^ exp_b[i][j]) c = (c >> 1) ^ 32'hEDB88320;
        else                    c = c >> 1;
    c = ~c;
    for (int k = 0; k < 4; k++) exp_b[68+k] = c[8*k +: 8];
  endtask

  task automatic pulse(input logic [15:0] d, input logic w);
    @(negedge clk);
    rdata = d; rw = w; valid = 1;
    @(negedge clk);
    valid = 0; rw = 0; rdata = 16'hDEAD;
  endtask

  // Captures from the current negedge onward (the one after the accepting edge).
  task automatic capture();
    int t;
    ndib = 0; gapn = 0; t = 0;
    for (int i = 0; i < NBYTES; i++) cap[i] = 8'h00;
    while (!txen && t < 20) begin @(negedge clk); t++; end
    while (txen && ndib < 400) begin
      if (ndib < 4*NBYTES) cap[ndib/4][2*(ndib%4) +: 2] = txd;
      ndib++;
      @(negedge clk);
    end
    while (busy && !txen && gapn < 200) begin
      if (txd !== 2'b00) begin fails++; checks++; $display("FAIL R10 actual=%0h expected=0", txd); end
      gapn++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input logic [15:0] d);
    logic ok;
    build_exp(d);
    chk("R2 frame dibits", ndib, 288);
    ok = 1; for (int i = 0; i < 7; i++) if (cap[i] !== 8'h55) ok = 0;
    chk("R3 preamble", ok, 1);
    chk("R3 delimiter", cap[7], 8'hD5);
    chk("R4 dst", {cap[8],cap[9],cap[10],cap[11],cap[12],cap[13]}, HOST);
    chk("R4 src", {cap[14],cap[15],cap[16],cap[17],cap[18],cap[19]}, DEV);
    chk("R4 ethertype", {cap[20],cap[21]}, ETYP);
    chk("R5 read data", {cap[22],cap[23]}, d);
    ok = 1; for (int i = 24; i < 68; i++) if (cap[i] !== 8'h00) ok = 0;
    chk("R5 padding", ok, 1);
    chk("R6 fcs", {cap[71],cap[70],cap[69],cap[68]},
        {exp_b[71],exp_b[70],exp_b[69],exp_b[68]});
    chk("R7 gap", gapn, 48);
    chk("R7 busy clears", busy, 0);
  endtask

  task automatic t_read(input logic [15:0] d);
    pulse(d, 0);
    capture();
    check_frame(d);
  endtask

  task automatic t_write();
    logic bad;
    bad = 0;
    pulse(16'h5A5A, 1);
    repeat (100) begin
      if (txen || busy) bad = 1;
      @(negedge clk);
    end
    chk("R8 write no frame", bad, 0);
  endtask

  task automatic t_drop();
    logic bad;
    pulse(16'h1234, 0);
    fork
      capture();
      begin
        repeat (60) @(negedge clk);
        rdata = 16'hBEEF; valid = 1;
        @(negedge clk);
        valid = 0;
      end
    join
    check_frame(16'h1234);
    bad = 0;
    repeat (100) begin
      if (txen || busy) bad = 1;
      @(negedge clk);
    end
    chk("R9 dropped strobe not queued", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txen reset", txen, 0);
    chk("R1 txd reset", txd, 0);
    chk("R1 busy reset", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_read(16'h0000);
    t_read(16'hFFFF);
    t_write();
    t_read(16'hA55A);
    t_drop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule